// File: doc/BRIEF.md
# Fill-then-copy double buffer

This block is a self-checking exchange buffer that sits behind a host bus slave. It holds two memories. The host writes only into the first one, which fills strictly in order, one location per accepted write, whatever address bits accompany the write. Once every location of the first memory holds a word, a hardware sequencer walks both memories through their second ports, which are wired to each other, and moves every word across into the second memory. The host reads only from the second memory, and only after that copy has finished.

Software uses the block to prove that the bus path works. It writes a block of words, waits for the ready flag, reads them back and compares. A write to one reserved control address restarts the fill for another round. Four status flags show the host where the buffer stands: write side full, copy in progress, read side ready, and writes lost.

Top module: `fcbuf_top`

## Requirements
- R1: After a synchronous reset, all four status flags read 0, `host_rd_valid` is 0 and `host_rd_data` is 0.
- R2: A host write to any address other than `CTRL_ADDR` stores its data at the next fill position. Positions run 0, 1, 2 and on. The other address bits have no effect on where the word lands.
- R3: The edge that accepts the DEPTH-th data write sets write-full (`status[0]`). Copy-busy (`status[1]`) rises at the next edge.
- R4: Copy-busy stays high for exactly DEPTH+1 cycles. At the edge where it drops, read-ready (`status[2]`) rises, and the read memory then holds every word of the write memory at the same index.
- R5: While write-full is set, data writes are ignored: they change no stored word and do not move the fill position. Each one sets overrun (`status[3]`), which stays set until reset.
- R6: A read requested while read-ready is 0 answers one cycle later with `host_rd_valid`=1 and `host_rd_data`=0, and changes no flag.
- R7: A read requested while read-ready is 1 answers one cycle later with `host_rd_valid`=1 and the word at `host_rd_addr`.
- R8: A write to `CTRL_ADDR`, with any data, returns the fill position to 0 and clears write-full, copy-busy and read-ready at the next edge, even in the middle of a copy. It leaves overrun unchanged.
- R9: Copy-busy and read-ready are never both set, and read-ready is only ever set together with write-full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_wr_addr | input | HAW | Host write address; only equality with `CTRL_ADDR` is decoded |
| host_wr_data | input | DW | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | clog2(DEPTH) | Index into the read memory |
| host_rd_data | output | DW | Read answer, zero unless the read was served while ready |
| host_rd_valid | output | 1 | High one cycle after each read strobe |
| status | output | 4 | {overrun, read-ready, copy-busy, write-full}, bit 3 down to bit 0 |

## Verification
The bench builds the block with DEPTH=8, DW=16 and HAW=5, with the control address at 5'h1F. The shallow memory makes a full fill, copy and readback round only about thirty cycles long. That leaves room for many random rounds, for an abort in the middle of a copy, for a clear in the middle of a fill, and for a check of the exact busy length, which is DEPTH+1 = 9 cycles. The narrow address bus lets random write addresses cover every non-control value, which shows that the fill order does not depend on them.

// File: rtl/fcbuf_pkg.sv
package fcbuf_pkg;

    typedef enum logic [1:0] {
        CP_IDLE = 2'd0,
        CP_RUN  = 2'd1,
        CP_DONE = 2'd2
    } cp_state_e;

    // bit 0 write-full, bit 1 copy-busy, bit 2 read-ready, bit 3 overrun
    typedef struct packed {
        logic overrun;
        logic rd_ready;
        logic copy_busy;
        logic wr_full;
    } fcbuf_status_t;

    function automatic int unsigned cnt_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fcbuf_sdpram.sv
module fcbuf_sdpram #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/fcbuf_fill.sv
module fcbuf_fill
    import fcbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_take,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          full,
    output logic          overrun
);
    localparam int CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] LAST_POS = CW'(DEPTH - 1);

    logic [CW-1:0] pos;

    assign ram_we   = wr_take && !full;
    assign ram_addr = pos[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else if (clr) begin
            pos  <= '0;
            full <= 1'b0;
        end else begin
            if (ram_we) begin
                pos <= pos + 1'b1;
                if (pos == LAST_POS) begin
                    full <= 1'b1;
                end
            end
            if (wr_take && full) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcbuf_copy.sv
module fcbuf_copy
    import fcbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          start,
    output logic          src_re,
    output logic [AW-1:0] src_addr,
    output logic          dst_we,
    output logic [AW-1:0] dst_addr,
    output logic          busy,
    output logic          done
);
    localparam int CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] END_CNT  = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    cp_state_e     state;
    logic [CW-1:0] idx;
    logic          pend;
    logic [AW-1:0] pend_idx;

    assign src_re   = (state == CP_RUN) && (idx < END_CNT);
    assign src_addr = idx[AW-1:0];
    assign dst_we   = pend;
    assign dst_addr = pend_idx;
    assign busy     = (state == CP_RUN);
    assign done     = (state == CP_DONE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state    <= CP_IDLE;
            idx      <= '0;
            pend     <= 1'b0;
            pend_idx <= '0;
        end else begin
            case (state)
                CP_IDLE: begin
                    pend <= 1'b0;
                    if (start) begin
                        state <= CP_RUN;
                        idx   <= '0;
                    end
                end
                CP_RUN: begin
                    // read index n now, write index n on the following edge
                    pend     <= src_re;
                    pend_idx <= idx[AW-1:0];
                    if (src_re) begin
                        idx <= idx + 1'b1;
                    end
                    if (pend && (pend_idx == LAST_IDX)) begin
                        state <= CP_DONE;
                    end
                end
                default: begin
                    pend <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fcbuf_rdport.sv
module fcbuf_rdport #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          ready,
    input  logic [DW-1:0] ram_q,
    output logic          ram_re,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic served;

    assign ram_re  = rd_en && ready;
    assign rd_data = served ? ram_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            served   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            served   <= ram_re;
            rd_valid <= rd_en;
        end
    end
endmodule

// File: rtl/fcbuf_top.sv
module fcbuf_top
    import fcbuf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int HAW   = 8,
    parameter logic [HAW-1:0] CTRL_ADDR = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_wr_en,
    input  logic [HAW-1:0]           host_wr_addr,
    input  logic [DW-1:0]            host_wr_data,
    input  logic                     host_rd_en,
    input  logic [$clog2(DEPTH)-1:0] host_rd_addr,
    output logic [DW-1:0]            host_rd_data,
    output logic                     host_rd_valid,
    output logic [3:0]               status
);
    localparam int AW = $clog2(DEPTH);

    logic          ctrl_hit;
    logic          data_wr;
    logic          w_we;
    logic [AW-1:0] w_addr;
    logic          full;
    logic          overrun;
    logic          cp_re;
    logic [AW-1:0] cp_raddr;
    logic          cp_we;
    logic [AW-1:0] cp_waddr;
    logic          busy;
    logic          done;
    logic [DW-1:0] link;
    logic          r_re;
    logic [DW-1:0] r_q;
    fcbuf_status_t st;

    assign ctrl_hit = host_wr_en && (host_wr_addr == CTRL_ADDR);
    assign data_wr  = host_wr_en && (host_wr_addr != CTRL_ADDR);

    fcbuf_fill #(.DEPTH(DEPTH), .AW(AW)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctrl_hit),
        .wr_take  (data_wr),
        .ram_we   (w_we),
        .ram_addr (w_addr),
        .full     (full),
        .overrun  (overrun)
    );

    fcbuf_sdpram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_wram (
        .clk   (clk),
        .we    (w_we),
        .waddr (w_addr),
        .wdata (host_wr_data),
        .re    (cp_re),
        .raddr (cp_raddr),
        .rdata (link)
    );

    fcbuf_copy #(.DEPTH(DEPTH), .AW(AW)) u_copy (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctrl_hit),
        .start    (full),
        .src_re   (cp_re),
        .src_addr (cp_raddr),
        .dst_we   (cp_we),
        .dst_addr (cp_waddr),
        .busy     (busy),
        .done     (done)
    );

    fcbuf_sdpram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rram (
        .clk   (clk),
        .we    (cp_we),
        .waddr (cp_waddr),
        .wdata (link),
        .re    (r_re),
        .raddr (host_rd_addr),
        .rdata (r_q)
    );

    fcbuf_rdport #(.DW(DW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (host_rd_en),
        .ready    (done),
        .ram_q    (r_q),
        .ram_re   (r_re),
        .rd_data  (host_rd_data),
        .rd_valid (host_rd_valid)
    );

    always_comb begin
        st.wr_full   = full;
        st.copy_busy = busy;
        st.rd_ready  = done;
        st.overrun   = overrun;
    end

    assign status = st;
endmodule

// File: rtl/fcbuf_chk.sv
module fcbuf_chk #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int HAW   = 8,
    parameter logic [HAW-1:0] CTRL_ADDR = '1
) (
    input logic           clk,
    input logic           rst,
    input logic           host_wr_en,
    input logic [HAW-1:0] host_wr_addr,
    input logic           host_rd_en,
    input logic [DW-1:0]  host_rd_data,
    input logic           host_rd_valid,
    input logic [3:0]     status
);
    logic        ctl;
    logic [15:0] busy_len;

    assign ctl = host_wr_en && (host_wr_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
        end else begin
            busy_len <= status[1] ? busy_len + 16'd1 : 16'd0;
        end
    end

    a_r9_busy_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(status[1] && status[2]));

    a_r9_ready_needs_full: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> status[0]);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        status[3] |=> status[3]);

    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !ctl) |=> status[0]);

    a_r3_busy_after_full: assert property (@(posedge clk) disable iff (rst)
        ($rose(status[0]) && !ctl) |=> status[1]);

    a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> (busy_len == 16'(DEPTH + 1)));

    a_r8_ctrl_clears: assert property (@(posedge clk) disable iff (rst)
        ctl |=> (status[2:0] == 3'b000));

    a_r6_zero_before_ready: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && !status[2]) |=> (host_rd_valid && (host_rd_data == '0)));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        host_rd_en |=> host_rd_valid);
endmodule

bind fcbuf_top fcbuf_chk #(
    .DW(DW), .DEPTH(DEPTH), .HAW(HAW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_wr_en    (host_wr_en),
    .host_wr_addr  (host_wr_addr),
    .host_rd_en    (host_rd_en),
    .host_rd_data  (host_rd_data),
    .host_rd_valid (host_rd_valid),
    .status        (status)
);

// File: tb/sim_fcbuf_top.sv
`timescale 1ns/1ps
module sim_fcbuf_top;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int HAW   = 5;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [HAW-1:0] CTRL = 5'h1F;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           host_wr_en = 1'b0;
    logic [HAW-1:0] host_wr_addr = '0;
    logic [DW-1:0]  host_wr_data = '0;
    logic           host_rd_en = 1'b0;
    logic [AW-1:0]  host_rd_addr = '0;
    logic [DW-1:0]  host_rd_data;
    logic           host_rd_valid;
    logic [3:0]     status;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  ovr_model = 1'b0;
    logic [DW-1:0] expv [DEPTH];

    always #5 clk = ~clk;

    fcbuf_top #(.DW(DW), .DEPTH(DEPTH), .HAW(HAW), .CTRL_ADDR(CTRL)) u0 (
        .clk (clk), .rst (rst),
        .host_wr_en (host_wr_en), .host_wr_addr (host_wr_addr), .host_wr_data (host_wr_data),
        .host_rd_en (host_rd_en), .host_rd_addr (host_rd_addr),
        .host_rd_data (host_rd_data), .host_rd_valid (host_rd_valid),
        .status (status)
    );

    function automatic logic [3:0] stat_of(input bit ovr, input bit rdy, input bit bsy, input bit ful);
        return {ovr, rdy, bsy, ful};
    endfunction

    function automatic logic [HAW-1:0] data_addr();
        return HAW'($urandom % 31);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hwrite(input logic [HAW-1:0] a, input logic [DW-1:0] d);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic hread(input int a, output logic [DW-1:0] d, output logic v);
        host_rd_en = 1'b1; host_rd_addr = AW'(a);
        tick();
        host_rd_en = 1'b0;
        d = host_rd_data; v = host_rd_valid;
    endtask

    // fill all locations; poke: 0 none, 1 write during copy, 2 write after done
    task automatic round(input int poke);
        logic [DW-1:0] d;
        logic v;
        int n;
        for (int i = 0; i < DEPTH; i++) begin
            expv[i] = DW'($urandom);
            hwrite(data_addr(), expv[i]);
            if (i == DEPTH - 2) chk("R3 not full before last word", 32'(status[0]), 32'd0);
        end
        chk("R3 full after last word", 32'(status), 32'(stat_of(ovr_model, 0, 0, 1)));
        tick();
        chk("R3 busy next cycle", 32'(status[1]), 32'd1);
        n = 1;
        while (status[1] && n < 100) begin
            if (poke == 1 && n == 3) begin
                hwrite(data_addr(), ~expv[0]);
                ovr_model = 1'b1;
            end else begin
                tick();
            end
            if (status[1]) n++;
        end
        chk("R4 busy length", 32'(n), 32'(DEPTH + 1));
        chk("R4 ready after copy", 32'(status), 32'(stat_of(ovr_model, 1, 0, 1)));
        if (poke == 2) begin
            hwrite(data_addr(), ~expv[DEPTH-1]);
            ovr_model = 1'b1;
            chk("R5 overrun on write while full", 32'(status[3]), 32'd1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            int a;
            a = (i * 3 + poke) % DEPTH;
            hread(a, d, v);
            chk("R7 read valid", 32'(v), 32'd1);
            chk("R7 R2 read word", 32'(d), 32'(expv[a]));
        end
    endtask

    initial begin
        logic [DW-1:0] d;
        logic v;
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 status after reset", 32'(status), 32'd0);
        chk("R1 rd_valid after reset", 32'(host_rd_valid), 32'd0);
        chk("R1 rd_data after reset", 32'(host_rd_data), 32'd0);

        hread(5, d, v);
        chk("R6 early read valid", 32'(v), 32'd1);
        chk("R6 early read zero", 32'(d), 32'd0);
        chk("R6 early read no state change", 32'(status), 32'd0);

        round(0);
        chk("R5 no overrun without stray writes", 32'(status[3]), 32'd0);
        hwrite(CTRL, 16'h1234);
        chk("R8 ctrl clears flags", 32'(status), 32'(stat_of(0, 0, 0, 0)));
        hread(2, d, v);
        chk("R6 read after clear is zero", 32'(d), 32'd0);

        // clear in the middle of a fill: fill restarts at position 0
        for (int i = 0; i < 3; i++) hwrite(data_addr(), 16'hDEAD);
        hwrite(CTRL, 16'h0);
        chk("R8 mid-fill clear", 32'(status[0]), 32'd0);
        round(0);
        hwrite(CTRL, 16'h0);

        round(1);
        chk("R5 overrun sticky after copy", 32'(status[3]), 32'd1);
        hwrite(CTRL, 16'h0);
        chk("R8 ctrl keeps overrun", 32'(status), 32'(stat_of(1, 0, 0, 0)));

        round(2);
        hwrite(CTRL, 16'h0);

        // abort a copy in progress
        for (int i = 0; i < DEPTH; i++) hwrite(data_addr(), DW'($urandom));
        tick(); tick();
        chk("R3 busy before abort", 32'(status[1]), 32'd1);
        hwrite(CTRL, 16'h0);
        chk("R8 abort copy", 32'(status), 32'(stat_of(1, 0, 0, 0)));
        repeat (DEPTH + 4) tick();
        chk("R8 no restart after abort", 32'(status), 32'(stat_of(1, 0, 0, 0)));
        hread(1, d, v);
        chk("R6 read after abort zero", 32'(d), 32'd0);

        for (int r = 0; r < 6; r++) begin
            round(r % 3);
            chk("R9 ready only with full", 32'(status[2:0]), 32'b101);
            hwrite(CTRL, DW'($urandom));
        end

        rst = 1'b1;
        tick();
        rst = 1'b0;
        ovr_model = 1'b0;
        tick();
        chk("R1 reset clears overrun", 32'(status), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule